// File: doc/BRIEF.md
# Multi-Device ROM Read Controller

This block sits between a processor-side read port and a bank of byte-wide, asynchronous, read-only memory devices that share one address bus, one data bus and one read strobe. A read request carries a flat address. The top bits pick the device and the low bits go out on the shared device address lines. The controller pulls low the chip-select of the chosen device only, so every other device stays in standby with its outputs floating. It drives a single shared output-enable strobe, waits the number of clock cycles the device speed grade needs, then captures the shared data bus and reports completion with a one-cycle ready pulse.

All wait counts come from parameters given in picoseconds: the address access time, the chip-select access time, the output-enable access time, the output float time and the clock period. The access wait is the larger of the address and chip-select access times, rounded up to whole cycles. The output-enable strobe is held back so that its own access window ends on the same cycle as the chip-select window. When the next read goes to a different device, the controller keeps its chip-select high until the previous device's outputs have had the float time to release the bus. A read to the device that was just used starts at once.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset every chip-select output is high, the output-enable strobe is high and ready is low.
- R2: The device index is addr_i[DEV_AW+DEV_W-1:DEV_AW] and the device address is addr_i[DEV_AW-1:0]. During an access exactly the chip-select bit at that index is low, and rom_addr_o carries the device address. At most one chip-select is low at any time.
- R3: The output-enable strobe is low only while a chip-select is low. It falls OE_DLY = ACC_CYC - OE_CYC edges after the chip-select falls, where OE_CYC = ceil(tOE / clock period).
- R4: ACC_CYC = ceil(max(tACC, tCE) / clock period). On the edge ACC_CYC cycles after the chip-select fell, the data bus is captured into rdata_o and ready_o is high for exactly one cycle.
- R5: Chip-select and output-enable both return high on the capture edge, so they are high in the cycle where ready_o is high.
- R6: When a read targets a device other than the last one accessed, its chip-select falls no earlier than FLOAT_CYC = ceil(tDF / clock period) edges after the previous chip-select rose. A read to the same device, or one issued after that gap, starts on its accept edge.
- R7: A request raised while an access or a turnaround wait is in progress is ignored. It produces no extra ready pulse and changes no chip-select.
- R8: rdata_o keeps the last captured byte until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request pulse, accepted when idle |
| addr_i | input | DEV_AW+DEV_W | Flat read address: device index above the device address |
| rdata_o | output | DATA_W | Captured read byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rom_addr_o | output | DEV_AW | Shared device address lines |
| ce_n_o | output | N_DEV | Per-device chip-selects, active low |
| oe_n_o | output | 1 | Shared output-enable strobe, active low |
| dq_i | input | DATA_W | Shared device data bus |

## Verification
The bench builds the controller with four devices, a 4 ns clock, 70 ns address access, 74 ns chip-select access, 35 ns output-enable access and 30 ns float time. The unequal access times make the chip-select time set the wait, at 19 cycles. The output-enable delay is 10 cycles. The float gap is 8 cycles, which is long enough that an immediate switch to another device, or one after a short idle spell, falls inside the turnaround window and is delayed by a number of cycles that differs from case to case. The modelled devices return a poison byte until their nanosecond timings are met, so capturing one edge early returns the wrong data.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_ACCESS = 2'd2
  } rd_state_e;

  function automatic int unsigned cdiv(int unsigned n, int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_dev_decode.sv
module rom_dev_decode #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned DEV_W = 2
) (
  input  logic [DEV_W-1:0] dev_i,
  output logic [N_DEV-1:0] sel_oh_o
);

  for (genvar g = 0; g < N_DEV; g++) begin : g_sel
    assign sel_oh_o[g] = (dev_i == DEV_W'(g));
  end

  always_comb begin
    assert ($countones(sel_oh_o) <= 1) else $error("AST_DEC_ONEHOT"); // R2
  end

endmodule

// File: rtl/rom_turn_guard.sv
module rom_turn_guard #(
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned FLOAT_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             release_i,
  input  logic [DEV_W-1:0] rel_dev_i,
  input  logic [DEV_W-1:0] cand_dev_i,
  output logic             ok_o
);

  localparam int unsigned GW = $clog2(FLOAT_CYC + 2);

  logic [GW-1:0]    gcnt_q;
  logic [DEV_W-1:0] last_q;
  logic             has_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q <= '0;
      last_q <= '0;
      has_q  <= 1'b0;
    end else if (release_i) begin
      gcnt_q <= GW'(FLOAT_CYC);
      last_q <= rel_dev_i;
      has_q  <= 1'b1;
    end else if (gcnt_q != '0) begin
      gcnt_q <= gcnt_q - 1'b1;
    end
  end

  // a start on this edge lands FLOAT_CYC edges after the release edge
  assign ok_o = !has_q || (cand_dev_i == last_q) || (gcnt_q <= GW'(1));

  AST_GUARD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcnt_q <= GW'(FLOAT_CYC)) else $error("AST_GUARD_BOUND"); // R6

endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
  import rom_rd_pkg::*;
#(
  parameter int unsigned ACC_CYC = 7,
  parameter int unsigned OE_DLY  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ok_i,
  output logic idle_o,
  output logic accept_o,
  output logic start_o,
  output logic sample_o,
  output logic oe_n_o
);

  localparam int unsigned CW = $clog2(ACC_CYC + 1);

  rd_state_e     st_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    idle_o   = (st_q == ST_IDLE);
    accept_o = idle_o && req_i;
    start_o  = (accept_o && ok_i) || ((st_q == ST_HOLD) && ok_i);
    sample_o = (st_q == ST_ACCESS) && (cnt_q == CW'(ACC_CYC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            if (ok_i) begin
              st_q  <= ST_ACCESS;
              cnt_q <= CW'(1);
            end else begin
              st_q  <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (ok_i) begin
            st_q  <= ST_ACCESS;
            cnt_q <= CW'(1);
          end
        end
        ST_ACCESS: begin
          if (sample_o) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_n_o <= 1'b1;
    end else if (sample_o) begin
      oe_n_o <= 1'b1;
    end else if (start_o && (OE_DLY == 0)) begin
      oe_n_o <= 1'b0;
    end else if ((st_q == ST_ACCESS) && (cnt_q == CW'(OE_DLY))) begin
      oe_n_o <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(ACC_CYC)) else $error("AST_CNT_RANGE"); // R4
  AST_OE_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (st_q == ST_ACCESS)) else $error("AST_OE_IN_ACCESS"); // R3
  AST_NO_REQ_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACCESS) && !sample_o |=> (st_q == ST_ACCESS)) else $error("AST_NO_REQ_EFFECT"); // R7

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEV_AW   = 17,
  parameter int unsigned N_DEV    = 4,
  parameter int unsigned DEV_W    = $clog2(N_DEV),
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_ACC_PS = 70000,
  parameter int unsigned T_CE_PS  = 70000,
  parameter int unsigned T_OE_PS  = 35000,
  parameter int unsigned T_DF_PS  = 30000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [DEV_AW+DEV_W-1:0] addr_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    ready_o,
  output logic [DEV_AW-1:0]       rom_addr_o,
  output logic [N_DEV-1:0]        ce_n_o,
  output logic                    oe_n_o,
  input  logic [DATA_W-1:0]       dq_i
);

  localparam int unsigned ACC_CYC   = umax(1, cdiv(umax(T_ACC_PS, T_CE_PS), CLK_PS));
  localparam int unsigned OE_RAW    = umax(1, cdiv(T_OE_PS, CLK_PS));
  localparam int unsigned OE_CYC    = (OE_RAW > ACC_CYC) ? ACC_CYC : OE_RAW;
  localparam int unsigned OE_DLY    = ACC_CYC - OE_CYC;
  localparam int unsigned FLOAT_CYC = cdiv(T_DF_PS, CLK_PS);
  localparam int unsigned QW        = $clog2(FLOAT_CYC + 2);

  logic             idle, accept, start, sample, ok;
  logic [DEV_W-1:0] dev_q, cand_dev;
  logic [N_DEV-1:0] sel_oh;

  assign cand_dev = idle ? addr_i[DEV_AW+DEV_W-1:DEV_AW] : dev_q;

  rom_dev_decode #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_dec (
    .dev_i    (cand_dev),
    .sel_oh_o (sel_oh)
  );

  rom_turn_guard #(.DEV_W(DEV_W), .FLOAT_CYC(FLOAT_CYC)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .release_i  (sample),
    .rel_dev_i  (dev_q),
    .cand_dev_i (cand_dev),
    .ok_o       (ok)
  );

  rom_rd_seq #(.ACC_CYC(ACC_CYC), .OE_DLY(OE_DLY)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .ok_i     (ok),
    .idle_o   (idle),
    .accept_o (accept),
    .start_o  (start),
    .sample_o (sample),
    .oe_n_o   (oe_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q      <= '0;
      rom_addr_o <= '0;
    end else if (accept) begin
      dev_q      <= addr_i[DEV_AW+DEV_W-1:DEV_AW];
      rom_addr_o <= addr_i[DEV_AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o <= '1;
    end else if (sample) begin
      ce_n_o <= '1;
    end else if (start) begin
      ce_n_o <= ~sel_oh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= sample;
      if (sample) rdata_o <= dq_i;
    end
  end

  // independent turnaround watch: idle cycles since the bus was last released
  logic [QW-1:0]    quiet_q;
  logic [N_DEV-1:0] last_pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q    <= '0;
      last_pat_q <= '1;
    end else if (&ce_n_o) begin
      if (quiet_q < QW'(FLOAT_CYC)) quiet_q <= quiet_q + 1'b1;
    end else begin
      quiet_q    <= '0;
      last_pat_q <= ce_n_o;
    end
  end

  AST_CE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_n_o) <= 1) else $error("AST_CE_ONEHOT"); // R2
  AST_OE_WITH_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !(&ce_n_o)) else $error("AST_OE_WITH_CE"); // R3
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o) else $error("AST_READY_PULSE"); // R4
  AST_RELEASE_AT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((&ce_n_o) && oe_n_o)) else $error("AST_RELEASE_AT_READY"); // R5
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&$past(ce_n_o)) && !(&ce_n_o) && !(&last_pat_q) && (ce_n_o != last_pat_q))
      |-> (quiet_q >= QW'(FLOAT_CYC))) else $error("AST_TURNAROUND"); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable(rdata_o)) else $error("AST_RDATA_HOLD"); // R8

endmodule

// File: tb/sim_rom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_rom_rd_ctrl;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEV_AW = 17;
  localparam int unsigned N_DEV  = 4;
  localparam int unsigned DEV_W  = 2;
  localparam int unsigned CLK_PS = 4000;
  localparam int unsigned T_ACC  = 70000;
  localparam int unsigned T_CE   = 74000;
  localparam int unsigned T_OE   = 35000;
  localparam int unsigned T_DF   = 30000;

  localparam int ACC_E    = ((T_CE > T_ACC ? T_CE : T_ACC) + CLK_PS - 1) / CLK_PS; // 19
  localparam int OE_E     = (T_OE + CLK_PS - 1) / CLK_PS;                          // 9
  localparam int OE_DLY_E = ACC_E - OE_E;                                          // 10
  localparam int FL_E     = (T_DF + CLK_PS - 1) / CLK_PS;                          // 8

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    req = 1'b0;
  logic [DEV_AW+DEV_W-1:0] addr = '0;
  logic [DATA_W-1:0]       rdata;
  logic                    ready;
  logic [DEV_AW-1:0]       rom_addr;
  logic [N_DEV-1:0]        ce_n;
  logic                    oe_n;
  logic [DATA_W-1:0]       dq = 8'hEE;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  rom_rd_ctrl #(
    .DATA_W(DATA_W), .DEV_AW(DEV_AW), .N_DEV(N_DEV), .DEV_W(DEV_W),
    .CLK_PS(CLK_PS), .T_ACC_PS(T_ACC), .T_CE_PS(T_CE), .T_OE_PS(T_OE), .T_DF_PS(T_DF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .rdata_o(rdata), .ready_o(ready), .rom_addr_o(rom_addr),
    .ce_n_o(ce_n), .oe_n_o(oe_n), .dq_i(dq)
  );

  function automatic logic [7:0] pat(int dev, logic [DEV_AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[16], 7'h0} ^ 8'(dev * 37) ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // device bank model, evaluated at the falling edge
  int                mon_ncyc = 0;
  int                ce_age = 0;
  int                oe_age = 0;
  bit                prev_low = 1'b0;
  int                prev_idx = -1;
  int                rel_ncyc = 0;
  int                rel_idx = -1;
  int                mon_oe_at = -1;
  logic [N_DEV-1:0]  mon_ce_pat = '1;
  logic [DEV_AW-1:0] mon_addr = '0;

  always @(negedge clk) begin
    int idx;
    bit low;
    idx = -1;
    for (int i = 0; i < N_DEV; i++) if (!ce_n[i]) idx = i;
    low = (idx >= 0);
    mon_ncyc++;
    if (low) ce_age++; else ce_age = 0;
    if (!oe_n) oe_age++; else oe_age = 0;
    if (low) begin
      mon_ce_pat = ce_n;
      mon_addr   = rom_addr;
      if (!oe_n && oe_age == 1) mon_oe_at = ce_age;
    end
    if (prev_low && !low) begin
      rel_ncyc = mon_ncyc;
      rel_idx  = prev_idx;
    end
    if (!prev_low && low && rel_idx >= 0 && idx != rel_idx)
      check((mon_ncyc - rel_ncyc) * int'(CLK_PS) >= int'(T_DF), "R6 float gap",
            mon_ncyc - rel_ncyc, FL_E);
    prev_low = low;
    prev_idx = idx;
    if (low && !oe_n && ce_age * int'(CLK_PS) >= int'(T_CE) &&
        ce_age * int'(CLK_PS) >= int'(T_ACC) && oe_age * int'(CLK_PS) >= int'(T_OE))
      dq <= pat(idx, rom_addr);
    else
      dq <= 8'hEE;
  end

  task automatic t_reset();
    @(negedge clk);
    check(ce_n == '1, "R1 ce after reset", ce_n, 4'hF);
    check(oe_n == 1'b1, "R1 oe after reset", oe_n, 1);
    check(ready == 1'b0, "R1 ready after reset", ready, 0);
  endtask

  // hold: edges the start is expected to wait for turnaround (R6)
  // stray_at: falling edge index at which an ignored request is raised (R7), 0 for none
  task automatic do_read(int dev, logic [DEV_AW-1:0] off, int hold, int stray_at);
    int n;
    logic [N_DEV-1:0] exp_pat;
    exp_pat = ~(N_DEV'(1) << dev);
    mon_oe_at = -1;
    mon_ce_pat = '1;
    @(negedge clk);
    req  = 1'b1;
    addr = {DEV_W'(dev), off};
    @(negedge clk);
    req = 1'b0;
    n = 1;
    while (!ready && n < 400) begin
      @(negedge clk);
      n++;
      if (n == stray_at && stray_at > 0) begin
        req  = 1'b1;
        addr = {DEV_W'((dev + 1) % N_DEV), off ^ 17'h00F0F};
      end else if (n == stray_at + 1 && stray_at > 0) begin
        req = 1'b0;
      end
    end
    check(n == ACC_E + hold + 1, hold > 0 ? "R6 latency with turnaround" : "R4 latency",
          n, ACC_E + hold + 1);
    check(rdata == pat(dev, off), "R4 data", rdata, pat(dev, off));
    check(mon_ce_pat == exp_pat, "R2 chip-select", mon_ce_pat, exp_pat);
    check(mon_addr == off, "R2 device address", mon_addr, off);
    check(mon_oe_at == OE_DLY_E + 1, "R3 oe delay", mon_oe_at, OE_DLY_E + 1);
    check((ce_n == '1) && oe_n, "R5 release at ready", {ce_n, oe_n}, 5'h1F);
  endtask

  task automatic t_quiet(int cycles, logic [7:0] keep);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ready || ce_n != '1) bad++;
    end
    check(bad == 0, "R7 no stray access", bad, 0);
    check(rdata == keep, "R8 rdata held", rdata, keep);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R4 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_read(0, 17'h00010, 0, 0);              // first access, no turnaround
    do_read(0, 17'h01234, 0, 0);              // same device back to back: R6 no wait
    do_read(2, 17'h1FFFF, FL_E - 2, 0);       // immediate switch: R6 wait
    idle(20);
    do_read(3, 17'h0ABCD, 0, 0);              // gap beyond float time
    idle(3);
    do_read(1, 17'h10000, FL_E - 5, 0);       // partial gap
    do_read(1, 17'h00777, 0, 5);              // stray request mid-access: R7
    t_quiet(40, pat(1, 17'h00777));
    do_read(0, 17'h00000, 0, 0);
    t_quiet(10, pat(0, 17'h00000));           // R8
    finish_run();
  end

endmodule